// File: doc/BRIEF.md
# External Memory Bus Cycle Stretcher

This block runs one read or write access to external data memory over a bus whose low byte carries the address first and the data after it. A one-clock start request, with a direction bit, a 16-bit address, write data and a 3-bit stretch setting, launches the access. The block then steps through four phases:

- an address latch phase, with the latch enable high and the low address byte driven;
- a setup phase;
- a strobe phase, with the active-low read or write strobe asserted;
- a hold phase.

The high address byte stays on its own port for the whole access. On a read, the byte on the bus is captured on the last strobe clock. A one-cycle completion pulse marks the final clock of the access.

The stretch setting trades speed for slack with slow devices. Setting 0 is the fastest access, at eight clocks. Settings 1 to 3 lengthen the strobe and give setup and hold one extra clock each. Settings 4 to 7 also widen the latch pulse and give setup and hold a further four clocks each. The setting is captured when the request is accepted, so it can be rewritten at any time without disturbing an access that is already running.

Top module: `xmem_cycle_stretcher`

## Requirements
- R1: While reset is held and after it, ale is 0, rdN and wrN are 1, addrOe and dataOe are 0, and busy and done are 0.
- R2: From the first cycle after acceptance, ale and addrOe are 1 for 2 cycles (settings 0 to 3) or 6 cycles (settings 4 to 7), and adOut carries addr[7:0] during that time.
- R3: The strobe is low for 2 cycles at setting 0 and for 4 times the setting at settings 1 to 7, which gives 4, 8, 12, 16, 20, 24 and 28.
- R4: Setup (between latch and strobe) and hold (after strobe) each last 2 cycles at setting 0, 3 cycles at settings 1 to 3, and 7 cycles at settings 4 to 7.
- R5: An access lasts 8 + 4*n cycles, where n is 0, 1, 2, 3, 7, 8, 9, 10 for settings 0 to 7.
- R6: A read (rdNotWr=1) drives only rdN low, never wrN, and leaves dataOe at 0. readData takes the rdBus value present on the last strobe cycle and keeps it after the access.
- R7: A write (rdNotWr=0) drives only wrN low. dataOe is 1 from the end of the latch phase through the last hold cycle, and adOut carries wrData during that time.
- R8: busy is 1 from the cycle after acceptance through the cycle of done. done is 1 for exactly one cycle, the last one of the access, and busy is 0 on the next cycle.
- R9: A start request while busy is 1 is ignored: the running access keeps its timing and its address, and no new access follows.
- R10: Changes to stretch, addr, wrData and rdNotWr after acceptance have no effect on the running access.
- R11: addrHi carries addr[15:8] for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Access request, accepted only while idle |
| rdNotWr | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Access address |
| wrData | input | 8 | Write data |
| stretch | input | 3 | Stretch setting 0 to 7 |
| rdBus | input | 8 | Sampled multiplexed bus value for reads |
| ale | output | 1 | Address latch enable, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| addrOe | output | 1 | Low address byte drive enable |
| dataOe | output | 1 | Write data drive enable |
| adOut | output | 8 | Value for the multiplexed low byte |
| addrHi | output | 8 | High address byte |
| readData | output | 8 | Captured read byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
All bus outputs are decoded from the phase register, so they change one edge after acceptance and one edge after each phase boundary. The bench gives cycle index 0 to the first falling edge after the accepting rising edge. It samples every output at each falling edge and compares it with a phase schedule worked out from that index and the setting's phase lengths. The captured read byte is due one edge after the last strobe cycle, so the bench records the rdBus value it drove on that cycle and compares it once the block is back in idle. The idle cycle after the done pulse is also checked, to confirm that busy has dropped and that no stray request started a new access.

// File: rtl/xmem_stretch_pkg.sv
package xmem_stretch_pkg;

  localparam int STRETCH_W = 3;
  localparam int MAX_PHASE = 4 * ((2 ** STRETCH_W) - 1);
  localparam int CNT_W     = $clog2(MAX_PHASE);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  typedef struct packed {
    logic load;
    logic aleOn;
    logic addrDrive;
    logic dataDrive;
    logic rdOn;
    logic wrOn;
    logic capture;
    logic done;
  } busCtrl_t;

  // latch-enable phase length
  function automatic int aleLen(input logic [STRETCH_W-1:0] s);
    return (s >= 3'd4) ? 6 : 2;
  endfunction

  // setup and hold share one length
  function automatic int edgeLen(input logic [STRETCH_W-1:0] s);
    if (s == '0) return 2;
    return (s >= 3'd4) ? 7 : 3;
  endfunction

  function automatic int strobeLen(input logic [STRETCH_W-1:0] s);
    if (s == '0) return 2;
    return 4 * int'(s);
  endfunction

endpackage

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
  import xmem_stretch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 rdNotWr,
  input  logic [STRETCH_W-1:0] stretch,
  output busCtrl_t             ctrl,
  output logic                 busy
);

  phase_t               phase;
  logic [CNT_W-1:0]     cnt;
  logic [STRETCH_W-1:0] sLat;
  logic                 readLat;
  logic                 lastTick;

  assign lastTick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      sLat    <= '0;
      readLat <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_ALE;
            cnt     <= CNT_W'(aleLen(stretch) - 1);
            sLat    <= stretch;
            readLat <= rdNotWr;
          end
        end
        PH_ALE: begin
          if (lastTick) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(edgeLen(sLat) - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SETUP: begin
          if (lastTick) begin
            phase <= PH_STROBE;
            cnt   <= CNT_W'(strobeLen(sLat) - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (lastTick) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(edgeLen(sLat) - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lastTick) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl           = '0;
    ctrl.load      = (phase == PH_IDLE) && start;
    ctrl.aleOn     = (phase == PH_ALE);
    ctrl.addrDrive = (phase == PH_ALE);
    ctrl.dataDrive = !readLat &&
                     ((phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD));
    ctrl.rdOn      = readLat && (phase == PH_STROBE);
    ctrl.wrOn      = !readLat && (phase == PH_STROBE);
    ctrl.capture   = readLat && (phase == PH_STROBE) && lastTick;
    ctrl.done      = (phase == PH_HOLD) && lastTick;
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/xmem_stretch_dp.sv
module xmem_stretch_dp
  import xmem_stretch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busCtrl_t                 ctrl,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        rdBus,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     addrOe,
  output logic                     dataOe,
  output logic [DATA_W-1:0]        adOut,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        readData,
  output logic                     done
);

  logic [ADDR_W-1:0] addrLat;
  logic [DATA_W-1:0] wrLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLat  <= '0;
      wrLat    <= '0;
      readData <= '0;
    end else begin
      if (ctrl.load) begin
        addrLat <= addr;
        wrLat   <= wrData;
      end
      if (ctrl.capture) begin
        readData <= rdBus;
      end
    end
  end

  assign adOut  = ctrl.addrDrive ? addrLat[DATA_W-1:0] : wrLat;
  assign addrHi = addrLat[ADDR_W-1:DATA_W];
  assign ale    = ctrl.aleOn;
  assign rdN    = !ctrl.rdOn;
  assign wrN    = !ctrl.wrOn;
  assign addrOe = ctrl.addrDrive;
  assign dataOe = ctrl.dataDrive;
  assign done   = ctrl.done;

endmodule

// File: rtl/xmem_cycle_stretcher.sv
module xmem_cycle_stretcher
  import xmem_stretch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     rdNotWr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [STRETCH_W-1:0]     stretch,
  input  logic [DATA_W-1:0]        rdBus,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     addrOe,
  output logic                     dataOe,
  output logic [DATA_W-1:0]        adOut,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        readData,
  output logic                     busy,
  output logic                     done
);

  busCtrl_t ctrl;

  xmem_stretch_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rdNotWr (rdNotWr),
    .stretch (stretch),
    .ctrl    (ctrl),
    .busy    (busy)
  );

  xmem_stretch_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .addr     (addr),
    .wrData   (wrData),
    .rdBus    (rdBus),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .addrOe   (addrOe),
    .dataOe   (dataOe),
    .adOut    (adOut),
    .addrHi   (addrHi),
    .readData (readData),
    .done     (done)
  );

endmodule

// File: rtl/xmem_stretch_chk.sv
module xmem_stretch_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic addrOe,
  input logic dataOe,
  input logic busy,
  input logic done
);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(!rdN && !wrN));

  // R2
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> (rdN && wrN && addrOe && !dataOe));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> busy);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy);

  // R7
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN) !wrN |-> dataOe);

  // R6
  read_float_chk: assert property (@(posedge clk) disable iff (!rstN) !rdN |-> !dataOe);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (!ale && rdN && wrN && !addrOe && !dataOe));

endmodule

bind xmem_cycle_stretcher xmem_stretch_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .ale    (ale),
  .rdN    (rdN),
  .wrN    (wrN),
  .addrOe (addrOe),
  .dataOe (dataOe),
  .busy   (busy),
  .done   (done)
);

// File: tb/xmem_cycle_stretcher_tb_top.sv
module xmem_cycle_stretcher_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        rdNotWr;
  logic [15:0] addr;
  logic [7:0]  wrData;
  logic [2:0]  stretch;
  logic [7:0]  rdBus;
  logic        ale, rdN, wrN, addrOe, dataOe, busy, done;
  logic [7:0]  adOut, addrHi, readData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xmem_cycle_stretcher dut_i (
    .clk(clk), .rstN(rstN), .start(start), .rdNotWr(rdNotWr), .addr(addr),
    .wrData(wrData), .stretch(stretch), .rdBus(rdBus), .ale(ale), .rdN(rdN),
    .wrN(wrN), .addrOe(addrOe), .dataOe(dataOe), .adOut(adOut), .addrHi(addrHi),
    .readData(readData), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // added stretch cycles per setting
  function automatic int addCycles(input logic [2:0] s);
    case (s)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 7;
      3'd5: return 8;
      3'd6: return 9;
      default: return 10;
    endcase
  endfunction

  function automatic int expTotal(input logic [2:0] s);
    return 8 + 4 * addCycles(s);
  endfunction

  function automatic int expStrobe(input logic [2:0] s);
    return (s == 3'd0) ? 2 : 4 * int'(s);
  endfunction

  function automatic int expAle(input logic [2:0] s);
    return (s > 3'd3) ? 6 : 2;
  endfunction

  function automatic int expEdge(input logic [2:0] s);
    return (expTotal(s) - expAle(s) - expStrobe(s)) / 2;
  endfunction

  task automatic doAccess(input logic [2:0] s, input logic rd, input logic [15:0] a,
                          input logic [7:0] wd, input bit noise);
    int al, b2, b3, tot;
    logic [7:0] sampled;
    sampled = 8'h00;
    al  = expAle(s);
    b2  = al + expEdge(s);
    b3  = b2 + expStrobe(s);
    tot = expTotal(s);
    @(negedge clk);
    start = 1'b1; stretch = s; rdNotWr = rd; addr = a; wrData = wd;
    @(negedge clk);
    for (int k = 0; k < tot; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2 ale", ale, (k < al));
      chk("R2 addrOe", addrOe, (k < al));
      if (k < al) chk("R2 adOut address", adOut, a[7:0]);
      chk("R4/R3 rdN", rdN, !(rd && k >= b2 && k < b3));
      chk("R4/R3 wrN", wrN, !(!rd && k >= b2 && k < b3));
      chk("R7 dataOe", dataOe, (!rd && k >= al));
      if (!rd && k >= al) chk("R7 adOut data", adOut, wd);
      chk("R11 addrHi", addrHi, a[15:8]);
      chk("R8 busy", busy, 1'b1);
      chk("R5 done", done, (k == tot - 1));
      rdBus = 8'($urandom);
      if (k == b3 - 1) sampled = rdBus;
      if (noise) begin
        // R9 R10: disturb every input during the access
        start   = 1'b1;
        stretch = 3'($urandom);
        rdNotWr = 1'($urandom);
        addr    = 16'($urandom);
        wrData  = 8'($urandom);
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy drops", busy, 1'b0);
    chk("R9 no new access", ale, 1'b0);
    chk("R8 done single", done, 1'b0);
    if (rd) chk("R6 readData", readData, sampled);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; start = 1'b1; rdNotWr = 1'b1; addr = 16'hA5A5;
    wrData = 8'h3C; stretch = 3'd0; rdBus = 8'h00;
    repeat (3) @(negedge clk);
    // R1 during reset, with start held high
    chk("R1 ale", ale, 1'b0);
    chk("R1 rdN", rdN, 1'b1);
    chk("R1 wrN", wrN, 1'b1);
    chk("R1 oe", {addrOe, dataOe}, 2'b00);
    chk("R1 busy", {busy, done}, 2'b00);
    start = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 1'b0);

    for (int s = 0; s < 8; s++) begin
      doAccess(3'(s), 1'b1, 16'h1200 + 16'(s), 8'h00, 1'b0);
      doAccess(3'(s), 1'b0, 16'hBE00 + 16'(s), 8'h40 + 8'(s), 1'b0);
    end
    // R9 R10 directed: mid-access noise at extremes
    doAccess(3'd0, 1'b1, 16'hFFFF, 8'h00, 1'b1);
    doAccess(3'd7, 1'b0, 16'h0000, 8'hFF, 1'b1);
    doAccess(3'd1, 1'b0, 16'h5A01, 8'h81, 1'b1);
    doAccess(3'd4, 1'b1, 16'h8004, 8'h00, 1'b1);

    for (int i = 0; i < 40; i++) begin
      doAccess(3'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule